// File: doc/BRIEF.md
# Conflict-Free Bank Number Generator for a Dual-Read Predictor

A branch direction predictor stores its tables in four single-ported banks and reads the entries for two fetch blocks in the same cycle. This block assigns a bank to each of the two blocks so that the two reads always go to different banks. No arbitration and no second read port are needed. The assignment is made one cycle before the arrays are accessed, which keeps it off the critical path. A registered copy of the result drives bank selection at the start of the access cycle.

Each cycle that carries a valid fetch pair supplies the address of the older block and the address of the younger block of the previous pair. Address bits [6:5] of a block form its candidate bank. The first block of the new pair takes the candidate bank from the older address, unless that bank equals the bank already held by the previous younger block. In that case it takes the next bank, wrapping from 3 to 0. The second block uses the same rule on the younger address, but it avoids the first block's bank. Because each block steps away from its neighbour, the two banks read in one cycle always differ. The first block's bank also differs from the bank of the block issued just before it.

Top module: `fetch_bank_sched`

## Requirements
- R1: With `pair_vld_i` high, `nxt_bank_a_o` equals `old_addr_i[6:5]` when that value differs from the last registered `sel_bank_b_o`. Otherwise it equals that value plus one, modulo 4.
- R2: With `pair_vld_i` high, `nxt_bank_b_o` equals `young_addr_i[6:5]` when that value differs from `nxt_bank_a_o`. Otherwise it equals that value plus one, modulo 4.
- R3: In every cycle with `pair_vld_i` high, `nxt_bank_a_o` and `nxt_bank_b_o` differ. In every cycle with `sel_vld_o` high, `sel_bank_a_o` and `sel_bank_b_o` differ.
- R4: The previous-bank state is the last valid pair's second bank. It is visible as `sel_bank_b_o` and is unchanged by cycles without a valid pair.
- R5: After reset, `sel_vld_o` is 0, both registered banks are 0, and the first valid pair avoids bank 0 for its first block.
- R6: One clock after a valid pair, `sel_vld_o` is 1 and `sel_bank_a_o` and `sel_bank_b_o` carry that pair's computed banks.
- R7: One clock after a cycle without a valid pair, `sel_vld_o` is 0 and both registered banks keep their values.
- R8: When a candidate bank 3 collides with the bank to be avoided, the result wraps to bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_vld_i | input | 1 | A fetch pair needs banks this cycle |
| old_addr_i | input | ADDR_W | Address of the older block of the previous pair |
| young_addr_i | input | ADDR_W | Address of the younger block of the previous pair |
| nxt_bank_a_o | output | 2 | Bank computed for the first block |
| nxt_bank_b_o | output | 2 | Bank computed for the second block |
| sel_vld_o | output | 1 | Registered banks are valid for this access cycle |
| sel_bank_a_o | output | 2 | Registered bank select for the first block |
| sel_bank_b_o | output | 2 | Registered bank select for the second block; also the previous-bank state |

## Verification
A wrong previous-bank value does not show in the cycle it goes wrong. It shows at the next valid pair, because the first block's bank then fails to step away from a colliding candidate, or steps away when it should not. An idle cycle that is allowed to disturb the state shows up at the first pair after it. The bench drives candidate fields that equal, or sit next to, the bank to be avoided. Comparing against a model of the rule then exposes a fault within one pair. Faults in the output registers show one clock after the pair that loads them.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int unsigned FBS_NUM_BANKS = 4;
  localparam int unsigned FBS_BANK_W    = $clog2(FBS_NUM_BANKS);
  localparam int unsigned FBS_SLOTS     = 2;

  typedef logic [FBS_BANK_W-1:0] bank_t;

  typedef struct packed {
    logic  vld;
    bank_t bank_a;
    bank_t bank_b;
  } bank_sel_t;
endpackage

// File: rtl/bank_pick.sv
module bank_pick
  import fbs_pkg::*;
(
  input  bank_t cand_i,
  input  bank_t avoid_i,
  output bank_t bank_o
);
  bank_t step;

  always_comb begin
    step   = cand_i + bank_t'(1);
    bank_o = (cand_i == avoid_i) ? step : cand_i;
  end
endmodule

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
  import fbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  bank_sel_t d_i,
  output bank_sel_t q_o
);
  bank_sel_t q_r;
  bank_sel_t q_nxt;

  always_comb begin
    q_nxt     = q_r;
    q_nxt.vld = en_i;
    if (en_i) begin
      q_nxt.bank_a = d_i.bank_a;
      q_nxt.bank_b = d_i.bank_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R7: the held banks move only on a loaded pair
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!q_r.vld && $stable(q_r.bank_a) && $stable(q_r.bank_b)));
endmodule

// File: rtl/fetch_bank_sched.sv
module fetch_bank_sched
  import fbs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BANK_LSB = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pair_vld_i,
  input  logic [ADDR_W-1:0]     old_addr_i,
  input  logic [ADDR_W-1:0]     young_addr_i,
  output logic [FBS_BANK_W-1:0] nxt_bank_a_o,
  output logic [FBS_BANK_W-1:0] nxt_bank_b_o,
  output logic                  sel_vld_o,
  output logic [FBS_BANK_W-1:0] sel_bank_a_o,
  output logic [FBS_BANK_W-1:0] sel_bank_b_o
);
  localparam int unsigned BANK_MSB = BANK_LSB + FBS_BANK_W - 1;

  bank_t     cand  [FBS_SLOTS];
  bank_t     avoid [FBS_SLOTS];
  bank_t     bank  [FBS_SLOTS];
  bank_sel_t sel_d;
  bank_sel_t sel_q;

  assign cand[0] = old_addr_i[BANK_MSB:BANK_LSB];
  assign cand[1] = young_addr_i[BANK_MSB:BANK_LSB];

  // previous younger bank is the registered second bank
  assign avoid[0] = sel_q.bank_b;

  for (genvar s = 0; s < FBS_SLOTS; s++) begin : g_slot
    if (s > 0) begin : g_chain
      assign avoid[s] = bank[s-1];
    end
    bank_pick u_pick (
      .cand_i  (cand[s]),
      .avoid_i (avoid[s]),
      .bank_o  (bank[s])
    );
  end

  always_comb begin
    sel_d.vld    = pair_vld_i;
    sel_d.bank_a = bank[0];
    sel_d.bank_b = bank[1];
  end

  bank_sel_reg u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (pair_vld_i),
    .d_i   (sel_d),
    .q_o   (sel_q)
  );

  assign nxt_bank_a_o = bank[0];
  assign nxt_bank_b_o = bank[1];
  assign sel_vld_o    = sel_q.vld;
  assign sel_bank_a_o = sel_q.bank_a;
  assign sel_bank_b_o = sel_q.bank_b;

  // R3: the two parallel reads never share a bank
  p_pair_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_i |-> (nxt_bank_a_o != nxt_bank_b_o));
  p_sel_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld_o |-> (sel_bank_a_o != sel_bank_b_o));
  // R1: the first block steps away from the previous younger block
  p_avoid_prev_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_i |-> (nxt_bank_a_o != sel_bank_b_o));
  // R6: registered copy follows the computed pair one clock later
  p_sel_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_i |=> (sel_vld_o && sel_bank_a_o == $past(nxt_bank_a_o)
                    && sel_bank_b_o == $past(nxt_bank_b_o)));
endmodule

// File: tb/fetch_bank_sched_bench.sv
module fetch_bank_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pair_vld_i;
  logic [31:0] old_addr_i;
  logic [31:0] young_addr_i;
  logic [1:0] nxt_bank_a_o, nxt_bank_b_o, sel_bank_a_o, sel_bank_b_o;
  logic       sel_vld_o;

  int checks = 0;
  int fails  = 0;
  logic [1:0] prev_m;
  logic [1:0] sel_a_m, sel_b_m;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  fetch_bank_sched u_fetch_bank_sched (
    .clk, .rst_n, .pair_vld_i, .old_addr_i, .young_addr_i,
    .nxt_bank_a_o, .nxt_bank_b_o, .sel_vld_o, .sel_bank_a_o, .sel_bank_b_o
  );

  function automatic logic [1:0] pick(input logic [1:0] c, input logic [1:0] av);
    return (c == av) ? c + 2'd1 : c;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] f, input logic [31:0] noise);
    return {noise[31:7], f, noise[4:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus with full checking
  task automatic step(input logic v, input logic [1:0] fy, input logic [1:0] fz,
                      input string ra, input string rb);
    logic [1:0] ea, eb;
    @(negedge clk);
    pair_vld_i   = v;
    old_addr_i   = mk(fy, $urandom);
    young_addr_i = mk(fz, $urandom);
    ea = pick(fy, prev_m);
    eb = pick(fz, ea);
    #1;
    if (v) begin
      chk(ra, nxt_bank_a_o, ea);
      chk(rb, nxt_bank_b_o, eb);
      chk("R3", 32'(nxt_bank_a_o != nxt_bank_b_o), 1);
    end
    @(posedge clk);
    #1;
    if (v) begin
      sel_a_m = ea; sel_b_m = eb; prev_m = eb;
    end
    chk(v ? "R6" : "R7", sel_vld_o, v);
    chk(v ? "R6" : "R7", sel_bank_a_o, sel_a_m);
    chk(v ? "R4" : "R7", sel_bank_b_o, sel_b_m);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pair_vld_i = 1'b0; old_addr_i = '0; young_addr_i = '0;
    prev_m = '0; sel_a_m = '0; sel_b_m = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R5", sel_vld_o, 0);
    chk("R5", sel_bank_a_o, 0);
    chk("R5", sel_bank_b_o, 0);
    @(negedge clk); rst_n = 1'b1;
    // first pair, candidate 0 must be pushed to 1
    step(1'b1, 2'd0, 2'd2, "R5", "R2");
    chk("R5", sel_bank_a_o, 1);
  endtask

  task automatic t_plain;
    step(1'b1, 2'd3, 2'd0, "R1", "R2");
    step(1'b1, 2'd1, 2'd2, "R1", "R2");
  endtask

  task automatic t_hit_a;
    // prev_m is 2 here
    step(1'b1, 2'd2, 2'd1, "R1", "R2");
    step(1'b1, 2'd1, 2'd0, "R1", "R2");
  endtask

  task automatic t_hit_b;
    step(1'b1, 2'd2, 2'd2, "R1", "R2");
    step(1'b1, 2'd0, 2'd0, "R1", "R2");
  endtask

  task automatic t_wrap;
    // force prev to 3 then collide candidate 3
    step(1'b1, 2'd1, 2'd3, "R1", "R2");
    step(1'b1, 2'd3, 2'd0, "R8", "R2");
    chk("R8", sel_bank_a_o, 0);
    step(1'b1, 2'd3, 2'd3, "R1", "R8");
  endtask

  task automatic t_idle_hold;
    step(1'b1, 2'd2, 2'd1, "R1", "R2");
    step(1'b0, 2'd1, 2'd2, "R7", "R7");
    step(1'b0, 2'd0, 2'd3, "R7", "R7");
    // next pair must still avoid the pre-idle bank
    step(1'b1, 2'd1, 2'd1, "R4", "R2");
  endtask

  task automatic t_stream;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], r[5:4], "R1", "R2");
    end
  endtask

  initial begin
    t_reset();
    t_plain();
    t_hit_a();
    t_hit_b();
    t_wrap();
    t_idle_hold();
    t_stream();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule